// File: doc/BRIEF.md
# Write-Protect Boundary Register With Permanent Lock

This block guards a small serial memory against unwanted writes. It holds a 6-bit boundary address and a valid flag. While the flag is set, every memory location at or above the boundary refuses writes. The serial front end decodes each frame into an opcode, an address field and the levels of two side-band inputs. It presents these together with a one-cycle frame-complete strobe. The block then carries out the boundary-register commands: arm, load, clear, lock and read.

On the memory side, the block answers two questions as a combinational function of the query address. Is a single-word write allowed? Is a fill of the whole array allowed? Changes to the boundary are two-step. An arm frame must come immediately before a load or clear frame, and the memory write-enable state must also be set. A lock command freezes the register for good. Only the power-on reset undoes it. A chip-select reset does not.

Top module: `wp_guard`

## Requirements
- R1: After power-on reset (synchronous, rst_n low at a clock edge), the boundary value is all ones (63), the valid flag is 0 and the lock flag is 0.
- R2: `wr_ok` is 1 exactly when `pe` is 1 and either the valid flag is 0 or `chk_addr` is strictly below the boundary value. It is combinational in `chk_addr` and `pe`.
- R3: `fill_ok` is 1 exactly when `pe` is 1 and the valid flag is 0.
- R4: A frame with `prot_sel`=1, `pe`=1, opcode 00 and address bits [5:4]=11 arms the register for the next frame only. Any other completed frame, whatever its `prot_sel` level, disarms it.
- R5: A frame with `prot_sel`=1, `pe`=1, opcode 01, `mem_wen`=1, arriving while armed, loads its address as the boundary and sets the valid flag to 1. The new value is visible after the clock edge on which `frame_done` is high.
- R6: A frame with `prot_sel`=1, `pe`=1, opcode 11, address 111111 and `mem_wen`=1, arriving while armed, sets the boundary to all ones and the valid flag to 0.
- R7: A frame with `prot_sel`=1, `pe`=1, opcode 00 and address 000000 sets the lock flag. No arming is needed.
- R8: While the lock flag is set, the boundary, the valid flag and the lock flag never change, and arm commands have no effect.
- R9: With `pe`=0, no frame changes the boundary, the valid flag or the lock flag.
- R10: Opcode 10 with `prot_sel`=1 (read), frames with `prot_sel`=0, and inputs presented without `frame_done` leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| frame_done | input | 1 | One-cycle strobe: a decoded frame is complete |
| op | input | 2 | Opcode field of the frame |
| addr | input | 6 | Address field of the frame |
| pe | input | 1 | Program-enable level; low refuses all write-type actions |
| prot_sel | input | 1 | High selects the boundary-register command set |
| mem_wen | input | 1 | Memory write-enable state held by the front end |
| chk_addr | input | 6 | Target address of a pending memory write |
| prot_value | output | 6 | Stored boundary, for serial readback |
| prot_valid | output | 1 | Boundary is in force |
| locked | output | 1 | Permanent lock flag |
| wr_ok | output | 1 | Single-word write to `chk_addr` allowed |
| fill_ok | output | 1 | Whole-array fill allowed |

## Verification
The embedded assertions check several properties on every cycle. The lock flag never falls, and a locked register never changes. With `pe` low the state never moves. A write at or above an active boundary is always refused, and a fill is refused while any boundary is valid. Some behaviour only the bench can show, through directed and random frame sequences checked against a reference model. That covers the arm-then-act ordering: an arm followed by some other frame loses its effect. It also covers the exact command encodings, the `mem_wen` gating, and the loaded values read back through `prot_value`.

// File: rtl/wpg_pkg.sv
// Package: shared command type for the write-protect boundary block.
// Assumes the decoder produces exactly one command per completed frame.
package wpg_pkg;
    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_READ  = 3'd1,
        CMD_ARM   = 3'd2,
        CMD_LOAD  = 3'd3,
        CMD_CLEAR = 3'd4,
        CMD_LOCK  = 3'd5
    } wpg_cmd_e;
endpackage

// File: rtl/wpg_decode.sv
// Module: wpg_decode
// Turns one frame (opcode, address field, side-band levels) into a
// boundary-register command. Write-type commands need pe high; read does not.
// Assumes inputs are stable in the cycle frame_done is sampled.
module wpg_decode
    import wpg_pkg::*;
#(
    parameter int AW  = 6,
    parameter int OPW = 2
) (
    input  logic [OPW-1:0] op,
    input  logic [AW-1:0]  addr,
    input  logic           pe,
    input  logic           prot_sel,
    output wpg_cmd_e       cmd
);
    localparam logic [AW-1:0] ADDR_ONES  = '1;
    localparam logic [AW-1:0] ADDR_ZEROS = '0;

    // Purpose: map the opcode and address qualifiers to a command.
    always_comb begin
        cmd = CMD_NONE;
        if (prot_sel) begin
            unique case (op)
                2'b10: cmd = CMD_READ;
                2'b01: cmd = pe ? CMD_LOAD : CMD_NONE;
                2'b11: cmd = (pe && addr == ADDR_ONES) ? CMD_CLEAR : CMD_NONE;
                2'b00: begin
                    if (pe && addr[AW-1 -: 2] == 2'b11)
                        cmd = CMD_ARM;
                    else if (pe && addr == ADDR_ZEROS)
                        cmd = CMD_LOCK;
                end
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/wpg_store.sv
// Module: wpg_store
// Holds the boundary, its valid flag, the one-time lock flag and the arm flag.
// Acts only on frame_done. Assumes rst_n is the power-on reset; chip-select
// resets are not wired here, so the state survives them.
module wpg_store
    import wpg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  wpg_cmd_e      cmd,
    input  logic [AW-1:0] addr,
    input  logic          pe,
    input  logic          mem_wen,
    output logic [AW-1:0] bound,
    output logic          bound_valid,
    output logic          lock_flag
);
    localparam logic [AW-1:0] BOUND_IDLE = '1;

    logic armed;
    logic may_change;

    assign may_change = frame_done && armed && mem_wen && !lock_flag;

    // Purpose: arm flag lives for exactly one following frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (frame_done)
            armed <= (cmd == CMD_ARM) && !lock_flag;
    end

    // Purpose: update boundary and valid flag on an armed load or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound       <= BOUND_IDLE;
            bound_valid <= 1'b0;
        end else if (may_change && cmd == CMD_LOAD) begin
            bound       <= addr;
            bound_valid <= 1'b1;
        end else if (may_change && cmd == CMD_CLEAR) begin
            bound       <= BOUND_IDLE;
            bound_valid <= 1'b0;
        end
    end

    // Purpose: set the permanent lock; only power-on reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_flag <= 1'b0;
        else if (frame_done && cmd == CMD_LOCK)
            lock_flag <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> lock_flag); // R8
    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |=> ($stable(bound) && $stable(bound_valid))); // R8
    AST_PE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |=> ($stable(bound) && $stable(bound_valid) && $stable(lock_flag))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> ($stable(bound) && $stable(bound_valid) && $stable(lock_flag))); // R10
endmodule

// File: rtl/wpg_compare.sv
// Module: wpg_compare
// Decides whether a single-word write or a whole-array fill may proceed.
// Assumes the boundary is inclusive: addresses >= bound are protected.
module wpg_compare #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] chk_addr,
    input  logic [AW-1:0] bound,
    input  logic          bound_valid,
    input  logic          pe,
    output logic          wr_ok,
    output logic          fill_ok
);
    logic in_range;

    // Purpose: inclusive threshold compare and pe gating.
    always_comb begin
        in_range = bound_valid && (chk_addr >= bound);
        wr_ok    = pe && !in_range;
        fill_ok  = pe && !bound_valid;
    end

    always_comb begin
        AST_WR_BLOCK: assert (!(bound_valid && chk_addr >= bound && wr_ok)); // R2
        AST_FILL_BLOCK: assert (!(bound_valid && fill_ok)); // R3
    end
endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard (top)
// Write-protect boundary register with permanent lock: decodes register
// commands, stores state, and answers write-permission queries.
// Assumes frame_done is a single-cycle strobe from the serial front end.
module wp_guard
    import wpg_pkg::*;
#(
    parameter int AW  = 6,
    parameter int OPW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_done,
    input  logic [OPW-1:0] op,
    input  logic [AW-1:0]  addr,
    input  logic           pe,
    input  logic           prot_sel,
    input  logic           mem_wen,
    input  logic [AW-1:0]  chk_addr,
    output logic [AW-1:0]  prot_value,
    output logic           prot_valid,
    output logic           locked,
    output logic           wr_ok,
    output logic           fill_ok
);
    wpg_cmd_e cmd;

    wpg_decode #(.AW(AW), .OPW(OPW)) u_dec (
        .op(op), .addr(addr), .pe(pe), .prot_sel(prot_sel), .cmd(cmd)
    );

    wpg_store #(.AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .cmd(cmd),
        .addr(addr), .pe(pe), .mem_wen(mem_wen),
        .bound(prot_value), .bound_valid(prot_valid), .lock_flag(locked)
    );

    wpg_compare #(.AW(AW)) u_cmp (
        .chk_addr(chk_addr), .bound(prot_value), .bound_valid(prot_valid),
        .pe(pe), .wr_ok(wr_ok), .fill_ok(fill_ok)
    );

    AST_LOCK_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(frame_done && prot_sel && pe)); // R7
endmodule

// File: tb/wp_guard_test.sv
module wp_guard_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       frame_done = 0;
    logic [1:0] op = 0;
    logic [5:0] addr = 0;
    logic       pe = 0;
    logic       prot_sel = 0;
    logic       mem_wen = 0;
    logic [5:0] chk_addr = 0;
    logic [5:0] prot_value;
    logic       prot_valid, locked, wr_ok, fill_ok;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // reference model
    logic [5:0] m_val = 6'h3F;
    bit m_valid = 0, m_lock = 0, m_arm = 0;

    always #4 clk = ~clk;

    wp_guard uut (.*);

    function automatic bit exp_wr(input logic [5:0] a, input bit p);
        return p && !(m_valid && a >= m_val);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " value"}, prot_value, m_val);
        chk({req, " valid"}, prot_valid, m_valid);
        chk({req, " lock"}, locked, m_lock);
    endtask

    task automatic model(input logic [1:0] o, input logic [5:0] a,
                         input bit p, input bit s, input bit w);
        bit arm_n;
        arm_n = 0;
        if (s && p && !m_lock) begin
            if (o == 2'b00 && a[5:4] == 2'b11) arm_n = 1;
            else if (o == 2'b00 && a == 0) m_lock = 1;
            else if (o == 2'b01 && m_arm && w) begin m_val = a; m_valid = 1; end
            else if (o == 2'b11 && a == 6'h3F && m_arm && w) begin m_val = 6'h3F; m_valid = 0; end
        end
        m_arm = arm_n;
    endtask

    task automatic frame(input logic [1:0] o, input logic [5:0] a,
                         input bit p, input bit s, input bit w, input string req);
        @(negedge clk);
        op = o; addr = a; pe = p; prot_sel = s; mem_wen = w; frame_done = 1;
        @(negedge clk);
        frame_done = 0;
        model(o, a, p, s, w);
        check_state(req);
    endtask

    task automatic query(input logic [5:0] a, input bit p, input string req);
        @(negedge clk);
        chk_addr = a; pe = p;
        #1;
        chk({req, " wr_ok"}, wr_ok, exp_wr(a, p));
        chk({req, " fill_ok"}, fill_ok, p && !m_valid);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1");
        query(6'd63, 1, "R1");
        // R5 load with arm
        frame(2'b00, 6'h30, 1, 1, 1, "R4");
        frame(2'b01, 6'd20, 1, 1, 1, "R5");
        query(6'd19, 1, "R2");
        query(6'd20, 1, "R2");
        query(6'd63, 1, "R3");
        query(6'd5, 0, "R2");
        // load without arm ignored
        frame(2'b01, 6'd10, 1, 1, 1, "R4");
        // arm then a non-protect frame disarms
        frame(2'b00, 6'h3A, 1, 1, 1, "R4");
        frame(2'b10, 6'd0, 1, 0, 1, "R10");
        frame(2'b01, 6'd8, 1, 1, 1, "R4");
        // mem_wen low blocks
        frame(2'b00, 6'h30, 1, 1, 0, "R4");
        frame(2'b01, 6'd8, 1, 1, 0, "R5");
        // read is harmless
        frame(2'b10, 6'd3, 0, 1, 1, "R10");
        // pe low blocks
        frame(2'b00, 6'h30, 0, 1, 1, "R9");
        frame(2'b01, 6'd9, 0, 1, 1, "R9");
        // clear needs all-ones address
        frame(2'b00, 6'h30, 1, 1, 1, "R6");
        frame(2'b11, 6'h3E, 1, 1, 1, "R6");
        frame(2'b00, 6'h30, 1, 1, 1, "R6");
        frame(2'b11, 6'h3F, 1, 1, 1, "R6");
        query(6'd63, 1, "R3");
        // random phase
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            logic [1:0] o;
            logic [5:0] a;
            int k;
            k = $urandom % 10;
            o = $urandom; a = $urandom;
            if (k < 3) begin o = 2'b00; a[5:4] = 2'b11; end
            else if (k < 5) o = 2'b01;
            else if (k == 5) begin o = 2'b11; a = 6'h3F; end
            else if (k == 6 && i > 300) begin o = 2'b00; a = 0; end
            frame(o, a, ($urandom % 8) != 0, ($urandom % 8) != 0,
                  ($urandom % 8) != 0, "R5");
            query($urandom, ($urandom % 8) != 0, "R2");
        end
        // directed lock
        frame(2'b00, 6'h30, 1, 1, 1, "R4");
        frame(2'b01, 6'd33, 1, 1, 1, "R5");
        frame(2'b00, 6'h00, 0, 1, 1, "R9");
        frame(2'b00, 6'h00, 1, 1, 1, "R7");
        frame(2'b00, 6'h30, 1, 1, 1, "R8");
        frame(2'b01, 6'd2, 1, 1, 1, "R8");
        frame(2'b00, 6'h30, 1, 1, 1, "R8");
        frame(2'b11, 6'h3F, 1, 1, 1, "R8");
        query(6'd32, 1, "R2");
        query(6'd33, 1, "R2");
        // power-on reset restores
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_val = 6'h3F; m_valid = 0; m_lock = 0; m_arm = 0;
        check_state("R1");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule